// File: doc/BRIEF.md
# Two-Button Single-Step Clock Generator

This block gives a slow, hand-operated clock to a small processor on a board whose oscillator runs at 50 MHz. The fast system clock samples two pushbuttons. One button is the "fall" button and sends the stepped clock low. The other is the "rise" button and sends it high. Each button can only move the clock toward its own level. Contact bounce on a button therefore repeats a request that has already been served, and it cannot add edges. No debounce counter is needed.

A two-state machine holds the stepped clock level. Both buttons pass through a two-flop synchronizer before the machine reads them. The block has two outputs. The first is the stepped clock level. The second is a pulse one system cycle wide, issued on every low-to-high step. A processor running on the system clock can use this pulse as its clock enable, so it advances exactly one instruction for each press pair.

Top module: `step_clock_gen`

## Requirements
- R1: While rst_ni is low, and on the first sampling after it is released, step_clk_o and step_pulse_o are both 0 (the low state).
- R2: A change on either button reaches the outputs at the third rising edge of clk_i after it is applied (two synchronizer flops, then the state flop).
- R3: In the low state, rise button high alone (btn_hi_i=1, btn_lo_i=0) moves step_clk_o to 1.
- R4: In the high state, fall button high alone (btn_lo_i=1, btn_hi_i=0) moves step_clk_o to 0.
- R5: In the low state the fall button has no effect on either output. In the high state the rise button has no effect on either output.
- R6: When both buttons are seen high together, step_clk_o keeps its value and step_pulse_o stays 0.
- R7: step_pulse_o is 1 for exactly the one clk_i cycle in which step_clk_o has just gone from 0 to 1, and it is 0 at all other times.
- R8: Bounce (any toggling) on the rise button after it caused a step produces no further step_pulse_o until the fall button has returned the clock low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz system clock that samples the buttons |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_lo_i | input | 1 | Fall button, raw and asynchronous, active high |
| btn_hi_i | input | 1 | Rise button, raw and asynchronous, active high |
| step_clk_o | output | 1 | Stepped clock level |
| step_pulse_o | output | 1 | One-cycle enable on each rising step |

## Verification
Directed sequences come first. A clean press of the rise button measures the three-edge latency and confirms the single pulse. Heavy toggling of the rise button while the clock is already high separates a correct design from one that re-arms on bounce. A press of the fall button while low, and a press of both buttons together, confirm that a request toward the current level, or a conflicting request, leaves the level unchanged. After that, long runs of random button levels with random hold lengths are compared cycle by cycle against a bench model built from the requirements. These runs cover arbitrary orderings and overlaps of the two buttons.

// File: rtl/step_clock_pkg.sv
package step_clock_pkg;

  typedef enum logic {
    STEP_LOW  = 1'b0,
    STEP_HIGH = 1'b1
  } step_state_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned NUM_BUTTONS     = 2;
  localparam int unsigned BTN_LO_IDX      = 0;
  localparam int unsigned BTN_HI_IDX      = 1;

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end

    assign sync_o[b] = chain_q[LAST];
  end

endmodule

// File: rtl/step_fsm.sv
module step_fsm
  import step_clock_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lo_req_i,
  input  logic hi_req_i,
  output logic level_o,
  output logic pulse_o
);

  step_state_e state_q, state_d;
  logic        pulse_d, pulse_q;

  always_comb begin
    state_d = state_q;
    pulse_d = 1'b0;
    unique case (state_q)
      STEP_LOW: if (hi_req_i && !lo_req_i) begin
        state_d = STEP_HIGH;
        pulse_d = 1'b1;
      end
      STEP_HIGH: if (lo_req_i && !hi_req_i) state_d = STEP_LOW;
      default: state_d = STEP_LOW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= STEP_LOW;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign level_o = (state_q == STEP_HIGH);
  assign pulse_o = pulse_q;

endmodule

// File: rtl/step_clock_gen.sv
module step_clock_gen
  import step_clock_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_lo_i,
  input  logic btn_hi_i,
  output logic step_clk_o,
  output logic step_pulse_o
);

  logic [NUM_BUTTONS-1:0] btn_raw, btn_sync;
  logic                   lo_req, hi_req;

  assign btn_raw[BTN_LO_IDX] = btn_lo_i;
  assign btn_raw[BTN_HI_IDX] = btn_hi_i;

  btn_sync #(
    .WIDTH  (NUM_BUTTONS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (btn_raw),
    .sync_o  (btn_sync)
  );

  assign lo_req = btn_sync[BTN_LO_IDX];
  assign hi_req = btn_sync[BTN_HI_IDX];

  step_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lo_req_i (lo_req),
    .hi_req_i (hi_req),
    .level_o  (step_clk_o),
    .pulse_o  (step_pulse_o)
  );

endmodule

// File: rtl/step_clock_gen_chk.sv
module step_clock_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lo_req,
  input logic hi_req,
  input logic step_clk_o,
  input logic step_pulse_o
);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_pulse_o |=> !step_pulse_o); // R7

  AST_PULSE_WITH_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_pulse_o |-> (step_clk_o && !$past(step_clk_o))); // R7

  AST_RISE_GIVES_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_clk_o) |-> step_pulse_o); // R7

  AST_RISE_NEEDS_HI_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_clk_o) |-> $past(hi_req && !lo_req)); // R3

  AST_FALL_NEEDS_LO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(step_clk_o) |-> $past(lo_req && !hi_req)); // R4

  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_req && hi_req) |=> ($stable(step_clk_o) && !step_pulse_o)); // R6

  AST_HIGH_NO_REPULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_clk_o && !lo_req) |=> (step_clk_o && !step_pulse_o)); // R8

  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (!step_clk_o && !step_pulse_o)); // R1

endmodule

bind step_clock_gen step_clock_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lo_req       (lo_req),
  .hi_req       (hi_req),
  .step_clk_o   (step_clk_o),
  .step_pulse_o (step_pulse_o)
);

// File: tb/step_clock_gen_tb.sv
module step_clock_gen_tb;

  localparam int CLK_PERIOD = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic btn_lo_i = 1'b0;
  logic btn_hi_i = 1'b0;
  logic step_clk_o, step_pulse_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic m_s1lo, m_s2lo, m_s1hi, m_s2hi, m_state, m_pulse;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  step_clock_gen u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .btn_lo_i     (btn_lo_i),
    .btn_hi_i     (btn_hi_i),
    .step_clk_o   (step_clk_o),
    .step_pulse_o (step_pulse_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_s1lo = 0; m_s2lo = 0; m_s1hi = 0; m_s2hi = 0; m_state = 0; m_pulse = 0;
  endfunction

  // Expected behaviour per requirement: rise on hi-only (R3), fall on lo-only (R4), else hold.
  function automatic void model_step(input logic lo, input logic hi);
    m_pulse = 1'b0;
    if (!m_state && m_s2hi && !m_s2lo) begin
      m_state = 1'b1;
      m_pulse = 1'b1;
    end else if (m_state && m_s2lo && !m_s2hi) begin
      m_state = 1'b0;
    end
    m_s2lo = m_s1lo; m_s2hi = m_s1hi;
    m_s1lo = lo;     m_s1hi = hi;
  endfunction

  // Drive at negedge, let one posedge pass, compare at the next negedge.
  task automatic cycle(input logic lo, input logic hi, input string tag);
    btn_lo_i = lo;
    btn_hi_i = hi;
    @(posedge clk_i);
    @(negedge clk_i);
    model_step(lo, hi);
    check({tag, " clk"}, step_clk_o, m_state);
    check({tag, " pulse"}, step_pulse_o, m_pulse);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    btn_lo_i = 1'b0;
    btn_hi_i = 1'b0;
    model_reset();
    repeat (3) @(negedge clk_i);
    check("R1 clk in reset", step_clk_o, 1'b0);
    check("R1 pulse in reset", step_pulse_o, 1'b0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk_i);
    do_reset();
    cycle(0, 0, "R1");

    // R2: latency of a rise press is three edges
    cycle(0, 1, "R2");
    check("R2 no early rise", step_clk_o, 1'b0);
    cycle(0, 1, "R2");
    check("R2 no early rise 2", step_clk_o, 1'b0);
    cycle(0, 1, "R2");
    check("R3 rise", step_clk_o, 1'b1);
    check("R7 pulse on rise", step_pulse_o, 1'b1);
    cycle(0, 1, "R7");
    check("R7 pulse one cycle", step_pulse_o, 1'b0);

    // R8: bounce on rise button while high
    for (int i = 0; i < 40; i++) begin
      cycle(0, logic'(i % 2), "R8");
      check("R8 no repulse", step_pulse_o, 1'b0);
      check("R5 hi ignored when high", step_clk_o, 1'b1);
    end

    // R6: both buttons held
    for (int i = 0; i < 6; i++) cycle(1, 1, "R6");
    check("R6 both hold high", step_clk_o, 1'b1);

    // R4: fall
    for (int i = 0; i < 4; i++) cycle(1, 0, "R4");
    check("R4 fall", step_clk_o, 1'b0);

    // R5: fall button bouncing while low
    for (int i = 0; i < 20; i++) cycle(logic'(i % 2), 0, "R5");
    check("R5 lo ignored when low", step_clk_o, 1'b0);
    check("R5 no pulse", step_pulse_o, 1'b0);

    for (int i = 0; i < 6; i++) cycle(1, 1, "R6");
    check("R6 both hold low", step_clk_o, 1'b0);

    // Random bouncing traffic
    for (int seg = 0; seg < 3000; seg++) begin
      logic lo, hi;
      int len;
      lo  = logic'($urandom_range(0, 1));
      hi  = logic'($urandom_range(0, 1));
      len = $urandom_range(1, 8);
      for (int k = 0; k < len; k++) cycle(lo, hi, "R3/R4/R7 random");
    end

    // Reset mid-run from the high state
    for (int i = 0; i < 4; i++) cycle(0, 1, "R3");
    do_reset();
    cycle(0, 0, "R1 after release");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule